// File: doc/BRIEF.md
# UART Receive Frame Engine

This block turns an asynchronous serial line into bytes. It works from a one-cycle tick that arrives sixteen times per bit period. From the falling edge of a start bit it follows the frame bit by bit. It samples every bit once, in the middle of the bit, and after the last stop bit it places the character in a small first-in first-out store. The consumer watches the store's fill level and pops characters one at a time. Baud-rate generation and transmission are handled elsewhere.

The frame shape is set by static configuration inputs:
- a two-bit format field chooses eight data bits without parity, eight data bits with parity, or seven data bits with parity;
- one bit chooses one or two stop bits;
- one bit chooses odd or even parity;
- separate enables control parity checking, framing detection and overrun detection.

Errors are collected in three sticky flags. A write-one-to-clear command port clears them one at a time, and the same port sets the receiver-enable bit.

Top module: `uart_rx_frame`

## Requirements
- R1: After reset the fill level is 0, all three error flags are 0 and the receiver-enable status is 0.
- R2: While receiver-enable is 0, line activity stores nothing. A command write with clr_data bit 3 set makes receiver-enable 1, and it stays 1 until reset.
- R3: A falling edge starts a frame only if the line is still low on the 8th tick after the edge is seen. Otherwise the receiver returns to idle and nothing is stored.
- R4: Data bits arrive least significant bit first. Format 2'b00 takes eight data bits and no parity bit, and stores the byte unchanged.
- R5: Format 2'b01 takes eight data bits and then a parity bit. Format 2'b10 takes seven data bits and then a parity bit, and stores the character with bit 7 equal to 0. Format 2'b11 behaves as format 2'b00.
- R6: With cfg_two_stop equal to 0 there is one stop bit; with 1 there are two. A low level sampled on any stop bit sets err_frame only when cfg_fe_en is 1. The character is stored either way.
- R7: In a parity format with cfg_par_en equal to 1, a parity error sets err_parity. A parity error means the count of ones over the data bits and the parity bit is odd when cfg_par_odd is 0, or even when it is 1. With cfg_par_en equal to 0 the parity bit is ignored.
- R8: Characters are read in arrival order. rd_data shows the oldest character while fill_level is above 0. A pulse on rd_en removes it. rd_en while the store is empty has no effect.
- R9: A character that completes while fill_level equals DEPTH is dropped and the stored contents are unchanged. It sets err_overrun only when cfg_oe_en is 1.
- R10: The flags are sticky. A command write clears err_frame with bit 0, err_parity with bit 1 and err_overrun with bit 2, each independently. If a flag's set event and its clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_mode | input | 2 | Frame format: 00 8 bits, 01 8 bits plus parity, 10 7 bits plus parity, 11 as 00 |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | Enables parity checking |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_fe_en | input | 1 | Enables framing error detection |
| cfg_oe_en | input | 1 | Enables overrun error detection |
| clr_wr | input | 1 | Command write strobe |
| clr_data | input | 4 | Bit 0 clears framing, bit 1 clears parity, bit 2 clears overrun, bit 3 sets receiver enable |
| rd_en | input | 1 | Pops the oldest character |
| rd_data | output | 8 | Oldest stored character |
| fill_level | output | $clog2(DEPTH+1) | Number of stored characters |
| err_frame | output | 1 | Sticky framing error flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_overrun | output | 1 | Sticky overrun error flag |
| rx_en | output | 1 | Receiver enable status |

## Verification
The delicate coincidence is a flag being set by a completing frame in the same cycle that software writes the matching clear bit. The bench sends a frame with a low stop bit and holds the framing clear bit asserted through the whole stop bit. It releases the command at the first sample where the fill level has risen, which is the cycle of completion. The framing flag must read 1 there. Randomly timed clears and pops between randomly configured frames cover the remaining mixes of set, clear and full store.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] FMT_8N = 2'b00;
  localparam logic [1:0] FMT_8P = 2'b01;
  localparam logic [1:0] FMT_7P = 2'b10;

  localparam int CMD_W       = 4;
  localparam int CMD_CLR_FE  = 0;
  localparam int CMD_CLR_PE  = 1;
  localparam int CMD_CLR_OE  = 2;
  localparam int CMD_SET_REN = 3;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              two_stop,
  input  logic              par_odd,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              fe_hit,
  output logic              pe_hit
);

  localparam int CW  = $clog2(OSR);
  localparam int BCW = $clog2(CHAR_W + 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rxd;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign line = sync_q[SYNC_STAGES-1];

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     tcnt_q, tcnt_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [CHAR_W-1:0] shreg_q, shreg_d;
  logic              pacc_q, pacc_d;
  logic              pe_q, pe_d;
  logic              fe_q, fe_d;
  logic              stop2_q, stop2_d;
  logic              done_q, done_d;

  logic              seven;
  logic              has_par;
  logic              last_bit;

  assign seven    = (mode == FMT_7P);
  assign has_par  = (mode == FMT_8P) || (mode == FMT_7P);
  assign last_bit = (bcnt_q == (seven ? BCW'(CHAR_W - 2) : BCW'(CHAR_W - 1)));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    pacc_d  = pacc_q;
    pe_d    = pe_q;
    fe_d    = fe_q;
    stop2_d = stop2_q;
    done_d  = 1'b0;
    if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (enable && !line) begin
            state_d = RX_START;
            tcnt_d  = '0;
          end
        end
        RX_START: begin
          if (tcnt_q == MID_CNT) begin
            tcnt_d = '0;
            if (!line) begin
              state_d = RX_DATA;
              bcnt_d  = '0;
              pacc_d  = 1'b0;
              pe_d    = 1'b0;
              fe_d    = 1'b0;
              stop2_d = 1'b0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tcnt_q == LAST_CNT) begin
            tcnt_d  = '0;
            shreg_d = {line, shreg_q[CHAR_W-1:1]};
            pacc_d  = pacc_q ^ line;
            bcnt_d  = bcnt_q + 1'b1;
            if (last_bit) state_d = has_par ? RX_PARITY : RX_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        RX_PARITY: begin
          if (tcnt_q == LAST_CNT) begin
            tcnt_d  = '0;
            pe_d    = ((pacc_q ^ line) != par_odd);
            state_d = RX_STOP;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tcnt_q == LAST_CNT) begin
            tcnt_d = '0;
            fe_d   = fe_q | !line;
            if (two_stop && !stop2_q) begin
              stop2_d = 1'b1;
            end else begin
              done_d  = 1'b1;
              state_d = RX_IDLE;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      pacc_q  <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      stop2_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      pacc_q  <= pacc_d;
      pe_q    <= pe_d;
      fe_q    <= fe_d;
      stop2_q <= stop2_d;
      done_q  <= done_d;
    end
  end

  assign done   = done_q;
  assign data   = seven ? {1'b0, shreg_q[CHAR_W-1:1]} : shreg_q;
  assign fe_hit = fe_q;
  assign pe_hit = pe_q;

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d;
  logic [AW-1:0] rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          push_ok;
  logic          pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (lvl_q != '0);

  always_comb begin
    wp_d  = push_ok ? adv(wp_q) : wp_q;
    rp_d  = pop_ok ? adv(rp_q) : rp_q;
    lvl_d = lvl_q;
    if (push_ok && !pop_ok)      lvl_d = lvl_q + 1'b1;
    else if (pop_ok && !push_ok) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign level = lvl_q;

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             fe_hit,
  input  logic             pe_hit,
  input  logic             full,
  input  logic             fe_en,
  input  logic             pe_en,
  input  logic             oe_en,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd,
  output logic             err_fe,
  output logic             err_pe,
  output logic             err_oe,
  output logic             ren
);

  logic             fe_q, fe_d;
  logic             pe_q, pe_d;
  logic             oe_q, oe_d;
  logic             ren_q, ren_d;
  logic [CMD_W-1:0] act;

  assign act = cmd_wr ? cmd : '0;

  always_comb begin
    fe_d  = (done && fe_hit && fe_en) || (fe_q && !act[CMD_CLR_FE]);
    pe_d  = (done && pe_hit && pe_en) || (pe_q && !act[CMD_CLR_PE]);
    oe_d  = (done && full && oe_en)   || (oe_q && !act[CMD_CLR_OE]);
    ren_d = ren_q || act[CMD_SET_REN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= 1'b0;
      pe_q  <= 1'b0;
      oe_q  <= 1'b0;
      ren_q <= 1'b0;
    end else begin
      fe_q  <= fe_d;
      pe_q  <= pe_d;
      oe_q  <= oe_d;
      ren_q <= ren_d;
    end
  end

  assign err_fe = fe_q;
  assign err_pe = pe_q;
  assign err_oe = oe_q;
  assign ren    = ren_q;

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_fe_en,
  input  logic              cfg_oe_en,
  input  logic              clr_wr,
  input  logic [CMD_W-1:0]  clr_data,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_data,
  output logic [LW-1:0]     fill_level,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              rx_en
);

  logic              fr_done;
  logic [CHAR_W-1:0] fr_data;
  logic              fr_fe;
  logic              fr_pe;
  logic              st_full;

  uart_rx_sampler #(
    .OSR         (OSR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rxd      (rxd),
    .enable   (rx_en),
    .mode     (cfg_mode),
    .two_stop (cfg_two_stop),
    .par_odd  (cfg_par_odd),
    .done     (fr_done),
    .data     (fr_data),
    .fe_hit   (fr_fe),
    .pe_hit   (fr_pe)
  );

  uart_rx_store #(
    .DEPTH (DEPTH),
    .DW    (CHAR_W)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fr_done),
    .wdata (fr_data),
    .pop   (rd_en),
    .rdata (rd_data),
    .level (fill_level),
    .full  (st_full)
  );

  uart_rx_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (fr_done),
    .fe_hit (fr_fe),
    .pe_hit (fr_pe),
    .full   (st_full),
    .fe_en  (cfg_fe_en),
    .pe_en  (cfg_par_en),
    .oe_en  (cfg_oe_en),
    .cmd_wr (clr_wr),
    .cmd    (clr_data),
    .err_fe (err_frame),
    .err_pe (err_parity),
    .err_oe (err_overrun),
    .ren    (rx_en)
  );

endmodule

module uart_rx_frame_chk #(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          clr_wr,
  input logic [3:0]    clr_data,
  input logic [1:0]    cfg_mode,
  input logic          cfg_oe_en,
  input logic [LW-1:0] fill_level,
  input logic          err_frame,
  input logic          err_parity,
  input logic          err_overrun,
  input logic          rx_en,
  input logic          fr_done,
  input logic [7:0]    fr_data,
  input logic          st_full
);

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH));

  p_ren_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> rx_en);

  p_ren_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[3]) |=> rx_en);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_en) |=> $stable(fill_level));

  p_seven_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && cfg_mode == 2'b10) |-> !fr_data[7]);

  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && st_full && !rd_en) |=> fill_level == LW'(DEPTH));

  p_overrun_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && st_full && cfg_oe_en) |=> err_overrun);

  p_fe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !(clr_wr && clr_data[0])) |=> err_frame);

  p_pe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !(clr_wr && clr_data[1])) |=> err_parity);

  p_oe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !(clr_wr && clr_data[2])) |=> err_overrun);

  p_fe_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[0] && !fr_done) |=> !err_frame);

endmodule

bind uart_rx_frame uart_rx_frame_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_rx_frame_bench.sv
module uart_rx_frame_bench;

  localparam int DEPTH = 4;
  localparam int OSR   = 16;
  localparam int TDIV  = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick16;
  logic          rxd;
  logic [1:0]    cfg_mode;
  logic          cfg_two_stop, cfg_par_en, cfg_par_odd, cfg_fe_en, cfg_oe_en;
  logic          clr_wr;
  logic [3:0]    clr_data;
  logic          rd_en;
  logic [7:0]    rd_data;
  logic [LW-1:0] fill_level;
  logic          err_frame, err_parity, err_overrun, rx_en;

  int total = 0;
  int bad   = 0;
  logic [7:0] q[$];
  bit e_fe, e_pe, e_oe;
  logic [1:0] tdiv;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv   <= '0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= tdiv + 1'b1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  uart_rx_frame #(.DEPTH(DEPTH), .OSR(OSR)) u_uart_rx_frame (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_mode(cfg_mode), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_fe_en(cfg_fe_en), .cfg_oe_en(cfg_oe_en),
    .clr_wr(clr_wr), .clr_data(clr_data), .rd_en(rd_en), .rd_data(rd_data),
    .fill_level(fill_level), .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .rx_en(rx_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int ticks);
    rxd = v;
    repeat (ticks * TDIV) @(negedge clk);
  endtask

  function automatic bit fmt_par(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  function automatic logic [7:0] exp_char(input logic [1:0] m, input logic [7:0] d);
    return (m == 2'b10) ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic send_line(input logic [7:0] d, input bit bad_par, input int bad_stop);
    int nb = (cfg_mode == 2'b10) ? 7 : 8;
    int ns = cfg_two_stop ? 2 : 1;
    logic p = cfg_par_odd ^ bad_par;
    hold_line(1'b0, OSR);
    for (int i = 0; i < nb; i++) begin
      hold_line(d[i], OSR);
      p = p ^ d[i];
    end
    if (fmt_par(cfg_mode)) hold_line(p, OSR);
    for (int s = 0; s < ns; s++) begin
      if (s == bad_stop) hold_line(1'b0, (s == ns - 1) ? 11 : OSR);
      else               hold_line(1'b1, OSR);
    end
    hold_line(1'b1, OSR);
  endtask

  task automatic check_state(input string tag);
    chk(fill_level == LW'(q.size()), {tag, " fill"}, fill_level, q.size());
    chk(err_frame == e_fe, {tag, " frame flag"}, err_frame, e_fe);
    chk(err_parity == e_pe, {tag, " parity flag"}, err_parity, e_pe);
    chk(err_overrun == e_oe, {tag, " overrun flag"}, err_overrun, e_oe);
  endtask

  task automatic run_frame(input logic [7:0] d, input bit bad_par, input int bad_stop,
                           input string tag);
    send_line(d, bad_par, bad_stop);
    if (q.size() < DEPTH) q.push_back(exp_char(cfg_mode, d));
    else if (cfg_oe_en)   e_oe = 1'b1;
    if (bad_stop >= 0 && cfg_fe_en)                   e_fe = 1'b1;
    if (bad_par && cfg_par_en && fmt_par(cfg_mode))   e_pe = 1'b1;
    check_state(tag);
  endtask

  task automatic pop_chk(input string tag);
    if (q.size() > 0) chk(rd_data == q[0], {tag, " data"}, rd_data, q[0]);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    chk(fill_level == LW'(q.size()), {tag, " fill after pop"}, fill_level, q.size());
  endtask

  task automatic command(input logic [3:0] bits);
    clr_wr   = 1'b1;
    clr_data = bits;
    @(negedge clk);
    clr_wr   = 1'b0;
    clr_data = '0;
    if (bits[0]) e_fe = 1'b0;
    if (bits[1]) e_pe = 1'b0;
    if (bits[2]) e_oe = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] m, input bit two, input bit pen,
                         input bit odd, input bit fen, input bit oen);
    cfg_mode = m; cfg_two_stop = two; cfg_par_en = pen;
    cfg_par_odd = odd; cfg_fe_en = fen; cfg_oe_en = oen;
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; clr_wr = 1'b0; clr_data = '0; rd_en = 1'b0;
    set_cfg(2'b00, 0, 0, 0, 1, 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    chk(rx_en == 1'b0, "R1 rx_en", rx_en, 0);

    // R2 receiver off: nothing stored
    send_line(8'h3C, 0, -1);
    chk(fill_level == 0, "R2 disabled receive", fill_level, 0);
    command(4'b1000);
    chk(rx_en == 1'b1, "R2 set enable", rx_en, 1);

    // R3 short low pulse is not a start bit
    hold_line(1'b0, 3);
    hold_line(1'b1, 2 * OSR);
    check_state("R3 glitch");

    // R4 plain eight-bit frames
    run_frame(8'hA5, 0, -1, "R4");
    pop_chk("R4");
    run_frame(8'h01, 0, -1, "R4");
    pop_chk("R4");

    // R5 formats
    set_cfg(2'b10, 0, 1, 0, 1, 1);
    run_frame(8'hFF, 0, -1, "R5 seven-bit");
    pop_chk("R5 seven-bit");
    set_cfg(2'b11, 0, 1, 0, 1, 1);
    run_frame(8'h96, 0, -1, "R5 reserved format");
    pop_chk("R5 reserved format");
    set_cfg(2'b01, 0, 1, 1, 1, 1);
    run_frame(8'h5A, 0, -1, "R5 eight plus parity");
    pop_chk("R5 eight plus parity");

    // R7 parity
    run_frame(8'h5B, 1, -1, "R7 odd bad");
    set_cfg(2'b10, 0, 1, 0, 1, 1);
    run_frame(8'h33, 0, -1, "R7 even good");
    set_cfg(2'b01, 0, 0, 0, 1, 1);
    command(4'b0010);
    run_frame(8'hC4, 1, -1, "R7 check off");
    pop_chk("R7"); pop_chk("R7"); pop_chk("R7");

    // R6 stop bits and framing, R10 independent clear
    set_cfg(2'b01, 1, 1, 0, 0, 1);
    run_frame(8'h11, 0, 1, "R6 framing disabled");
    run_frame(8'h22, 1, -1, "R6 two stop good");
    cfg_fe_en = 1'b1;
    run_frame(8'h44, 0, 0, "R6 first stop low");
    command(4'b0001);
    check_state("R10 clear frame only");
    command(4'b0010);
    check_state("R10 clear parity");
    pop_chk("R6"); pop_chk("R6"); pop_chk("R6");

    // R9 overrun, R8 order and empty pop
    set_cfg(2'b00, 0, 0, 0, 1, 1);
    for (int i = 0; i <= DEPTH; i++) run_frame(8'(i * 37 + 5), 0, -1, "R9 fill");
    for (int i = 0; i < DEPTH; i++) pop_chk("R8 order");
    pop_chk("R8 empty pop");
    command(4'b0100);
    cfg_oe_en = 1'b0;
    for (int i = 0; i <= DEPTH; i++) run_frame(8'(i * 11 + 2), 0, -1, "R9 overrun disabled");
    for (int i = 0; i < DEPTH; i++) pop_chk("R8 order");
    cfg_oe_en = 1'b1;

    // R10 set and clear in the same cycle
    fork
      send_line(8'h77, 0, 0);
      begin
        repeat (9 * OSR * TDIV) @(negedge clk);
        clr_wr = 1'b1; clr_data = 4'b0001;
        while (fill_level == 0) @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
        chk(err_frame == 1'b1, "R10 set beats clear", err_frame, 1);
      end
    join
    q.push_back(8'h77);
    e_fe = 1'b1;
    check_state("R10 after collision");
    pop_chk("R10");
    command(4'b0001);

    // random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d = 8'($urandom);
      int bs;
      set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
      bs = (($urandom % 4) == 0) ? int'($urandom % (cfg_two_stop ? 2 : 1)) : -1;
      run_frame(d, ($urandom % 4) == 0, bs, "R4 R5 R6 R7 R9 random");
      if (($urandom % 2) == 0) pop_chk("R8 random");
      if (($urandom % 3) == 0) begin
        command({1'b0, 3'($urandom)});
        check_state("R10 random clear");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule